// File: doc/BRIEF.md
# Sector FIFO Service Requester

This block sits between a host bus and the byte stream of a disk data path. It holds a 16-byte FIFO and decides when the host must be asked to move data. A disk-to-host (read) transfer fills the FIFO from the disk side and empties it through host read strobes. A host-to-disk (write) transfer does the reverse. The request goes out either as an interrupt line with a matching ready-for-master status bit, or as a DMA request pin. The mode bit selects which. The point at which the request goes out is set by a programmable threshold. Read and write transfers use it differently: for reads the request waits until the FIFO holds depth-minus-threshold bytes, and for writes it is re-armed once the FIFO drains to the threshold.

The block counts bytes per sector on both sides, using a programmed sector length and number of sectors. It withdraws the DMA request as soon as the acknowledge marks the final host byte. It reacts to terminal count by letting the disk side finish the sector it is in: on writes it pads with zero bytes, and on reads it drops the bytes. A transfer can also run to the end of the programmed sectors without terminal count, or be cut short by an overrun or underrun on the disk side. In every case it enters a result phase with an empty FIFO and a status that separates normal from abnormal endings.

Top module: `sector_fifo_svc`

## Requirements
- R1: Bytes leave the FIFO in the order they entered, on both directions. A host write while 16 bytes are held is ignored, and so is a host read while the FIFO is empty.
- R2: The effective threshold is `cfg_thr_m1 + 1` (1 to 16).
- R3: Read direction (`cfg_h2d` = 0): the request is active while the FIFO is non-empty and any of these holds: occupancy is at least 16 minus the threshold; the last byte of a sector has entered and the FIFO has not yet emptied; or the request was active in the previous cycle. It drops when the FIFO is empty.
- R4: Write direction (`cfg_h2d` = 1): the request is active from the first execution cycle until the FIFO is full. It comes back once occupancy is at or below the threshold.
- R5: With `cfg_dma` = 0 the request drives `irq` and `rqm` and `drq` stays low. With `cfg_dma` = 1 it drives `drq`, and `irq` and `rqm` stay low.
- R6: In DMA mode `drq` is low in any cycle where `dma_ack` is high while the next host byte is the last of the transfer. After the last host byte has been moved, no request is raised.
- R7: Terminal count is `tc` together with `dma_ack` high in DMA mode, or `tc` with `dma_ack` low in interrupt mode. From the next cycle the host request is off and host strobes are ignored. The disk side finishes its current sector: on writes it reads zero bytes once the FIFO is empty, and on reads its bytes are dropped.
- R8: `busy` is high for the execution phase. `result` rises one clock after the disk side has moved its final byte, once the FIFO is empty (or at once after terminal count, which flushes the FIFO). It also rises at the edge after an overrun or underrun.
- R9: Status is cleared by `start`. An ending after terminal count gives `st_abn` = 0. An ending at the last programmed sector without terminal count gives `st_abn` = 1 and `st_eot` = 1.
- R10: A disk byte offered (`dsk_put`) while the FIFO is full and no terminal count has been seen sets `st_ovr` and `st_abn` and ends the transfer.
- R11: A disk byte requested (`dsk_take`) while the FIFO is empty and no terminal count has been seen sets `st_unr` and `st_abn` and ends the transfer.
- R12: After reset, every request, phase and status output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_dma | input | 1 | 1 = DMA request pin, 0 = interrupt and status bit |
| cfg_h2d | input | 1 | 1 = host-to-disk, 0 = disk-to-host |
| cfg_thr_m1 | input | 4 | Threshold minus one |
| cfg_sec_len | input | 11 | Bytes per sector, at least 1 |
| cfg_sec_num | input | 8 | Sectors in the transfer, at least 1 |
| start | input | 1 | Enter execution phase (ignored while busy) |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | FIFO head byte for host reads |
| dma_ack | input | 1 | DMA acknowledge, active high |
| tc | input | 1 | Terminal count |
| dsk_put | input | 1 | Disk side delivers a byte |
| dsk_din | input | 8 | Byte from the disk side |
| dsk_take | input | 1 | Disk side consumes a byte |
| dsk_dout | output | 8 | Byte to the disk side (zero when FIFO empty) |
| irq | output | 1 | Interrupt request |
| rqm | output | 1 | Ready-for-master status bit |
| drq | output | 1 | DMA request |
| busy | output | 1 | Execution phase |
| result | output | 1 | Result phase |
| st_abn | output | 1 | Abnormal termination |
| st_eot | output | 1 | Ended at last sector without terminal count |
| st_ovr | output | 1 | Disk-side overrun |
| st_unr | output | 1 | Disk-side underrun |

## Verification
A wrong occupancy count or a stuck hysteresis bit shows on the request pins in the cycle right after the edge that moved a byte. It shows as a request that comes one byte early or late, or that stays on against a full or empty FIFO. Broken sector counters show up later, at a sector boundary: the request appears when the last sector byte is pushed, `result` rises too early or too late, and a terminal-count sector is not padded correctly on `dsk_dout`. Status errors stay hidden until the result phase and can only be seen there.

// File: rtl/sector_fifo_svc.sv
module sector_fifo_svc #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int LENW  = 11,
  parameter int SECW  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_dma,
  input  logic            cfg_h2d,
  input  logic [AW-1:0]   cfg_thr_m1,
  input  logic [LENW-1:0] cfg_sec_len,
  input  logic [SECW-1:0] cfg_sec_num,
  input  logic            start,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [DW-1:0]   host_wdata,
  output logic [DW-1:0]   host_rdata,
  input  logic            dma_ack,
  input  logic            tc,
  input  logic            dsk_put,
  input  logic [DW-1:0]   dsk_din,
  input  logic            dsk_take,
  output logic [DW-1:0]   dsk_dout,
  output logic            irq,
  output logic            rqm,
  output logic            drq,
  output logic            busy,
  output logic            result,
  output logic            st_abn,
  output logic            st_eot,
  output logic            st_ovr,
  output logic            st_unr
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  typedef enum logic [1:0] {PH_IDLE, PH_EXEC, PH_RES} phase_t;

  phase_t          ph;
  logic [DW-1:0]   mem [DEPTH];
  logic [AW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;
  logic [LENW-1:0] hpos, dpos;
  logic [SECW-1:0] hsec, dsec;
  logic            hold, fp, tcs, hdone, ddone;

  wire exec  = (ph == PH_EXEC);
  wire empty = (cnt == '0);
  wire full  = (cnt == FULL);
  wire [CW-1:0]   thr    = {1'b0, cfg_thr_m1} + CW'(1);
  wire [LENW-1:0] len_m1 = cfg_sec_len - LENW'(1);
  wire [SECW-1:0] num_m1 = cfg_sec_num - SECW'(1);

  wire host_last = (hpos == len_m1) && (hsec == num_m1);
  wire dlb       = (dpos == len_m1);
  wire dls       = (dsec == num_m1);

  wire tc_hit    = exec & tc & (cfg_dma ? dma_ack : ~dma_ack);
  wire host_live = exec & ~tcs & ~hdone;
  wire h_rd      = host_live & ~cfg_h2d & host_rd & ~empty;
  wire h_wr      = host_live &  cfg_h2d & host_wr & ~full;
  wire h_xfer    = h_rd | h_wr;

  wire d_put  = exec & ~ddone & ~cfg_h2d & dsk_put;
  wire d_take = exec & ~ddone &  cfg_h2d & dsk_take;
  wire d_move = d_put | d_take;
  wire ovr_ev = d_put  & ~tcs & full;
  wire unr_ev = d_take & ~tcs & empty;
  wire d_push = d_put  & ~tcs & ~full;
  wire d_pop  = d_take & ~empty;
  wire d_fin  = d_move & dlb & (dls | tcs);

  wire push   = h_wr | d_push;
  wire pop    = h_rd | d_pop;
  wire finish = exec & (ovr_ev | unr_ev | (ddone & (empty | tcs)));

  wire rd_act = host_live & ~cfg_h2d & ~empty & ((cnt >= FULL - thr) | fp | hold);
  wire wr_act = host_live &  cfg_h2d & ~full  & (hold | (cnt <= thr));
  wire act    = rd_act | wr_act;

  assign irq        = ~cfg_dma & act;
  assign rqm        = ~cfg_dma & act;
  assign drq        =  cfg_dma & act & ~(dma_ack & host_last);
  assign busy       = exec;
  assign result     = (ph == PH_RES);
  assign host_rdata = mem[rp];
  assign dsk_dout   = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= cfg_h2d ? host_wdata : dsk_din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE;
      wp <= '0; rp <= '0; cnt <= '0;
      hpos <= '0; hsec <= '0; dpos <= '0; dsec <= '0;
      hold <= 1'b0; fp <= 1'b0; tcs <= 1'b0; hdone <= 1'b0; ddone <= 1'b0;
      st_abn <= 1'b0; st_eot <= 1'b0; st_ovr <= 1'b0; st_unr <= 1'b0;
    end else if (!exec) begin
      if (start) begin
        ph <= PH_EXEC;
        wp <= '0; rp <= '0; cnt <= '0;
        hpos <= '0; hsec <= '0; dpos <= '0; dsec <= '0;
        hold <= cfg_h2d; fp <= 1'b0; tcs <= 1'b0; hdone <= 1'b0; ddone <= 1'b0;
        st_abn <= 1'b0; st_eot <= 1'b0; st_ovr <= 1'b0; st_unr <= 1'b0;
      end
    end else if (finish) begin
      ph <= PH_RES;
      wp <= '0; rp <= '0; cnt <= '0;
      hold <= 1'b0; fp <= 1'b0;
      st_ovr <= ovr_ev;
      st_unr <= unr_ev;
      st_eot <= ~ovr_ev & ~unr_ev & ~tcs;
      st_abn <= ovr_ev | unr_ev | ~tcs;
    end else begin
      if (push) wp <= (wp == LAST_PTR) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == LAST_PTR) ? '0 : rp + AW'(1);
      cnt  <= cnt + CW'(push) - CW'(pop);
      hold <= act;
      if (d_push & dlb)                    fp <= 1'b1;
      else if (pop & ~push & (cnt == CW'(1))) fp <= 1'b0;
      tcs   <= tcs | tc_hit;
      hdone <= hdone | (h_xfer & host_last);
      ddone <= ddone | d_fin;
      if (h_xfer) begin
        if (hpos == len_m1) begin hpos <= '0; hsec <= hsec + SECW'(1); end
        else hpos <= hpos + LENW'(1);
      end
      if (d_move) begin
        if (dlb) begin dpos <= '0; dsec <= dsec + SECW'(1); end
        else dpos <= dpos + LENW'(1);
      end
    end
  end

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  assert_rd_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec & ~cfg_h2d & empty) |-> ~(irq | drq));
  assert_wr_full_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec & cfg_h2d & full) |-> ~(irq | drq));
  assert_tc_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tc_hit |=> ~(irq | rqm | drq));
  assert_result_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result |-> empty);
  assert_fault_abnormal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (result & (st_ovr | st_unr)) |-> st_abn);
endmodule

// File: tb/sector_fifo_svc_tb.sv
module sector_fifo_svc_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic cfg_dma = 0, cfg_h2d = 0, start = 0, host_rd = 0, host_wr = 0;
  logic dma_ack = 0, tc = 0, dsk_put = 0, dsk_take = 0;
  logic [3:0]  cfg_thr_m1 = 0;
  logic [10:0] cfg_sec_len = 11'd1;
  logic [7:0]  cfg_sec_num = 8'd1, host_wdata = 0, dsk_din = 0;
  logic [7:0]  host_rdata, dsk_dout;
  logic irq, rqm, drq, busy, result, st_abn, st_eot, st_ovr, st_unr;

  sector_fifo_svc u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_dma(cfg_dma), .cfg_h2d(cfg_h2d),
    .cfg_thr_m1(cfg_thr_m1), .cfg_sec_len(cfg_sec_len), .cfg_sec_num(cfg_sec_num),
    .start(start), .host_rd(host_rd), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .dma_ack(dma_ack), .tc(tc), .dsk_put(dsk_put),
    .dsk_din(dsk_din), .dsk_take(dsk_take), .dsk_dout(dsk_dout), .irq(irq),
    .rqm(rqm), .drq(drq), .busy(busy), .result(result), .st_abn(st_abn),
    .st_eot(st_eot), .st_ovr(st_ovr), .st_unr(st_unr));

  int n_chk = 0, n_err = 0;
  int m_ph = 0, m_cnt = 0, hpos = 0, hsec = 0, dpos = 0, dsec = 0;
  bit m_hold, m_fp, m_tcs, m_hdone, m_ddone, m_tc_prev;
  bit e_abn, e_eot, e_ovr, e_unr;
  byte unsigned q[$];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_hlast();
    return hpos == int'(cfg_sec_len) - 1 && hsec == int'(cfg_sec_num) - 1;
  endfunction

  function automatic bit m_act();
    int thr = int'(cfg_thr_m1) + 1;
    bit live = (m_ph == 1) && !m_tcs && !m_hdone;
    if (!cfg_h2d) return live && m_cnt != 0 && (m_cnt >= 16 - thr || m_fp || m_hold);
    return live && m_cnt != 16 && (m_hold || m_cnt <= thr);
  endfunction

  task automatic check_outputs();
    bit a = m_act();
    bit ei = !cfg_dma && a;
    bit ed = cfg_dma && a && !(dma_ack && m_hlast());
    string t = cfg_h2d ? "R4" : "R3";
    int thr = int'(cfg_thr_m1) + 1;
    chk(irq == ei && rqm == ei, t, "irq/rqm", int'({irq, rqm}), int'({ei, ei}));
    chk(drq == ed, (cfg_dma && a && dma_ack && m_hlast()) ? "R6" : t, "drq", drq, ed);
    chk(cfg_dma ? (irq == 0 && rqm == 0) : (drq == 0), "R5", "mode routing", int'({irq, rqm, drq}), 0);
    if (!cfg_dma && !cfg_h2d && m_ph == 1 && !m_tcs && !m_hdone && !m_hold && !m_fp && m_cnt != 0)
      chk(irq == (m_cnt >= 16 - thr), "R2", "threshold level", irq, m_cnt >= 16 - thr);
    if (m_tc_prev) chk(!irq && !drq, "R7", "request after tc", int'({irq, drq}), 0);
    chk(busy == (m_ph == 1) && result == (m_ph == 2), "R8", "phase", int'({busy, result}), m_ph);
    if (m_ph == 1 && !cfg_h2d && host_rd && !m_tcs && !m_hdone && m_cnt != 0)
      chk(host_rdata == q[0], "R1", "host_rdata", host_rdata, q[0]);
    if (m_ph == 1 && cfg_h2d && dsk_take && !m_ddone) begin
      if (m_cnt != 0) chk(dsk_dout == q[0], "R1", "dsk_dout", dsk_dout, q[0]);
      else if (m_tcs) chk(dsk_dout == 0, "R7", "pad byte", dsk_dout, 0);
    end
  endtask

  task automatic model_edge();
    int len = int'(cfg_sec_len);
    bit ex = (m_ph == 1);
    bit a = m_act();
    bit hl = m_hlast();
    bit hit = ex && tc && (cfg_dma ? dma_ack : !dma_ack);
    bit live = ex && !m_tcs && !m_hdone;
    bit hrd = live && !cfg_h2d && host_rd && m_cnt != 0;
    bit hwr = live && cfg_h2d && host_wr && m_cnt != 16;
    bit dput = ex && !m_ddone && !cfg_h2d && dsk_put;
    bit dtake = ex && !m_ddone && cfg_h2d && dsk_take;
    bit ovr = dput && !m_tcs && m_cnt == 16;
    bit unr = dtake && !m_tcs && m_cnt == 0;
    bit pok = dput && !m_tcs && m_cnt != 16;
    bit pd = dtake && m_cnt != 0;
    bit dlb = (dpos == len - 1);
    bit dls = (dsec == int'(cfg_sec_num) - 1);
    bit dfin = (dput || dtake) && dlb && (dls || m_tcs);
    bit fin = ex && (ovr || unr || (m_ddone && (m_cnt == 0 || m_tcs)));
    m_tc_prev = hit;
    if (!ex) begin
      if (start) begin
        m_ph = 1; q.delete(); m_cnt = 0; hpos = 0; hsec = 0; dpos = 0; dsec = 0;
        m_hold = cfg_h2d; m_fp = 0; m_tcs = 0; m_hdone = 0; m_ddone = 0;
        e_abn = 0; e_eot = 0; e_ovr = 0; e_unr = 0;
      end
    end else if (fin) begin
      m_ph = 2; q.delete(); m_cnt = 0; m_hold = 0; m_fp = 0;
      e_ovr = ovr; e_unr = unr; e_eot = !ovr && !unr && !m_tcs; e_abn = ovr || unr || !m_tcs;
    end else begin
      if (pok && dlb) m_fp = 1;
      else if ((hrd || pd) && !(hwr || pok) && m_cnt == 1) m_fp = 0;
      if (hrd || pd) void'(q.pop_front());
      if (hwr) q.push_back(host_wdata);
      if (pok) q.push_back(dsk_din);
      m_cnt = q.size();
      m_hold = a;
      m_tcs = m_tcs || hit;
      m_hdone = m_hdone || ((hrd || hwr) && hl);
      m_ddone = m_ddone || dfin;
      if (hrd || hwr) begin
        if (hpos == len - 1) begin hpos = 0; hsec++; end else hpos++;
      end
      if (dput || dtake) begin
        if (dlb) begin dpos = 0; dsec++; end else dpos++;
      end
    end
  endtask

  task automatic tick();
    #1 check_outputs();
    @(posedge clk);
    model_edge();
    #1;
  endtask

  // mode: 0 normal, 1 force overrun, 2 force underrun
  task automatic run(input bit dma, input bit h2d, input int thrm1, input int len,
                     input int num, input int tcat, input int mode);
    int cyc = 0;
    bit tc_done = 0;
    cfg_dma = dma; cfg_h2d = h2d; cfg_thr_m1 = 4'(thrm1);
    cfg_sec_len = 11'(len); cfg_sec_num = 8'(num);
    host_rd = 0; host_wr = 0; tc = 0; dsk_put = 0; dsk_take = 0; dma_ack = 0;
    start = 1;
    tick();
    start = 0;
    while (m_ph == 1 && cyc < 5000) begin
      int hcount = hsec * len + hpos;
      cyc++;
      host_rd = 0; host_wr = 0; tc = 0; dsk_put = 0; dsk_take = 0;
      dma_ack = dma ? 1'($urandom % 2) : 1'b0;
      if (tcat >= 0 && !tc_done && hcount == tcat && !m_hdone) begin
        tc = 1; dma_ack = dma; tc_done = 1;
      end else if (mode == 0 && ($urandom % 2) == 1) begin
        if (h2d) begin host_wr = 1; host_wdata = 8'($urandom); end
        else host_rd = 1;
        if (dma) dma_ack = 1;
      end
      if (($urandom % 5) < 2 || mode != 0) begin
        if (!h2d) begin
          if (m_cnt < 16 || m_tcs || mode == 1) begin dsk_put = 1; dsk_din = 8'($urandom); end
        end else if (m_cnt > 0 || m_tcs || mode == 2) dsk_take = 1;
      end
      tick();
    end
    host_rd = 0; host_wr = 0; tc = 0; dsk_put = 0; dsk_take = 0; dma_ack = 0;
    chk(m_ph == 2, "R8", "transfer reached result", m_ph, 2);
    #1;
    chk(st_abn == e_abn, "R9", "st_abn", st_abn, e_abn);
    chk(st_eot == e_eot, "R9", "st_eot", st_eot, e_eot);
    chk(st_ovr == e_ovr, "R10", "st_ovr", st_ovr, e_ovr);
    chk(st_unr == e_unr, "R11", "st_unr", st_unr, e_unr);
    tick();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EC7_0A11));
    repeat (3) @(posedge clk);
    #2;
    chk({irq, rqm, drq, busy, result} == 0, "R12", "reset requests", int'({irq, rqm, drq, busy, result}), 0);
    chk({st_abn, st_eot, st_ovr, st_unr} == 0, "R12", "reset status", int'({st_abn, st_eot, st_ovr, st_unr}), 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1;
    run(0, 0, 3, 20, 2, -1, 0);
    run(1, 0, 0, 16, 3, 20, 0);
    run(0, 1, 7, 24, 2, -1, 0);
    run(1, 1, 15, 32, 2, 40, 0);
    run(1, 1, 2, 10, 1, -1, 0);
    run(0, 1, 3, 12, 2, 5, 0);
    run(0, 0, 9, 12, 2, 15, 0);
    run(0, 0, 5, 32, 1, -1, 1);
    run(1, 1, 4, 8, 1, -1, 2);
    run(1, 0, 11, 1, 4, -1, 0);
    for (int i = 0; i < 10; i++) begin
      int l = 1 + int'($urandom % 30);
      int n = 1 + int'($urandom % 3);
      int t = ($urandom % 2) ? int'($urandom % (l * n)) : -1;
      run(1'($urandom % 2), 1'($urandom % 2), int'($urandom % 16), l, n, t, 0);
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule